// File: doc/BRIEF.md
# Multi-Page Write Cache with Page Flush

This block collects the data bytes of one serial write command in a small line-organised cache, then moves them to a page-programmed nonvolatile array once the command ends. A command opens with a start address. Each strobed byte is stored at the next position of a six-bit cache pointer. The pointer's low bits start at the byte offset of the start address within its page, and its line bits start at zero. When the pointer runs past the last byte of a line it moves on to the next line. When it runs past the last line it wraps back to line 0 byte 0, and later bytes overwrite earlier ones.

On a Stop the block becomes busy and programs the array one page at a time. Only pages that hold loaded bytes are programmed. Each page gets one program strobe, carrying the page number, the eight data bytes and a byte-valid mask. After the strobe the block holds busy for a fixed number of clock cycles per page. While busy, every command input is ignored. An abort, such as a repeated Start on the bus, throws the loaded bytes away without programming anything.

Top module: `wcache_flush`

## Requirements
- R1: After reset, busy is 0 and no page program strobe (pg_we) is issued until a command and a Stop have been received.
- R2: The first byte of a command lands in cache line 0 at the byte position given by start address bits 2..0. Line 0 is programmed to array page start_address[ADDR_W-1:3].
- R3: Each further byte takes the next byte position, and each line takes the next line. Cache line k is programmed to array page (start page + k) modulo 2^(ADDR_W-3), so a flush can cross row boundaries, 4K-bit block boundaries and the top of the array.
- R4: If the pointer passes line 7 byte 7, it wraps to line 0 byte 0. A later byte overwrites the earlier byte at the same position, and only the last value written to a position is programmed.
- R5: A byte that wraps into line 0 below the start offset is programmed to array page (start page + 8) modulo 2^(ADDR_W-3).
- R6: In each program strobe, mask bit b is 1 exactly for a loaded byte at position b (data byte b is bits 8b+7..8b of pg_data). Array bytes outside the mask keep their old contents, and the mask of a strobe is never zero.
- R7: No page is programmed while bytes are being loaded. Busy rises only in the cycle after a Stop.
- R8: Each programmed page gets exactly one pg_we pulse, in the first cycle of its own window of PAGE_CYC cycles. Busy lasts exactly (number of programmed pages) x PAGE_CYC cycles.
- R9: While busy is high, start, byte, Stop and abort inputs have no effect: no extra pages are programmed afterwards and the busy time is unchanged.
- R10: An abort while loading ends the command with nothing programmed and busy staying low.
- R11: A Stop with no byte loaded programs nothing and does not raise busy.
- R12: A new start while loading discards the bytes loaded so far and begins a fresh command at the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Opens a write command at start_addr |
| start_addr | input | ADDR_W | Byte address of the first data byte |
| byte_stb | input | 1 | One data byte is present this cycle |
| byte_data | input | DATA_W | Data byte |
| stop | input | 1 | End of command; starts the flush |
| abort | input | 1 | Ends the command and discards the cache |
| busy | output | 1 | Flush in progress |
| pg_we | output | 1 | Program strobe for one array page |
| pg_page | output | ADDR_W-3 | Array page number being programmed |
| pg_data | output | 8*DATA_W | Eight data bytes, byte b at bits 8b+7..8b |
| pg_mask | output | 8 | Byte-valid mask for pg_data |

## Verification
The bench builds the block with its full geometry (13-bit addresses, 8 lines of 8 bytes) and with PAGE_CYC set to 3, so that each page window takes only a few cycles. With these values, every start offset can be swept against byte counts on both sides of 8, 64 and 128. This covers single partial pages, full caches, single and double wraparound, and wrapped head bytes going to the ninth page, at start pages spread over the array and at its top. A byte-level model of the whole array compares every location after each flush, so bytes outside the mask are checked as well as the pages that were written.

// File: rtl/wcache_pkg.sv
// Shared types for the write cache.
package wcache_pkg;
    // Controller phases: waiting for a command, collecting bytes, programming pages.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } wc_state_e;
endpackage

// File: rtl/wc_store.sv
// Byte storage of the cache with one valid bit per byte slot.
// Assumes: clr and wr_en are never asserted together by the controller;
// if they are, clr wins for the valid bits.
module wc_store #(
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 8,
    parameter int DATA_W     = 8,
    localparam int SLOTS_B   = LINES * LINE_BYTES,
    localparam int PTR_W     = $clog2(SLOTS_B),
    localparam int LINE_W    = $clog2(LINES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         wr_en,
    input  logic [PTR_W-1:0]             wr_ptr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [LINE_W-1:0]            rd_line,
    output logic [LINE_BYTES*DATA_W-1:0] rd_data,
    output logic [SLOTS_B-1:0]           valid_all
);

    logic [DATA_W-1:0] mem [SLOTS_B];

    // Data capture: a strobed byte goes to the pointer position.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Valid bits: cleared by reset or command start, set on capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            valid_all <= '0;
        end else if (wr_en) begin
            valid_all[wr_ptr] <= 1'b1;
        end
    end

    // Line read port feeding the page program bus.
    always_comb begin
        for (int b = 0; b < LINE_BYTES; b++) begin
            rd_data[b*DATA_W +: DATA_W] = mem[int'(rd_line) * LINE_BYTES + b];
        end
    end

endmodule

// File: rtl/wc_slots.sv
// Maps cache lines to flush slots and finds the slots to program.
// Slot 0 is line 0 at or above the start offset, slots 1..LINES-1 are
// whole lines, slot LINES is line 0 below the start offset (wrapped head).
// Assumes: cur is always below LINES+1 while used.
module wc_slots #(
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 8,
    localparam int SLOTS_B   = LINES * LINE_BYTES,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int SLOTS     = LINES + 1,
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input  logic [SLOTS_B-1:0]    valid_all,
    input  logic [OFF_W-1:0]      offset,
    input  logic [SLOT_W-1:0]     cur,
    output logic [LINE_BYTES-1:0] cur_mask,
    output logic [SLOT_W-1:0]     first_slot,
    output logic                  first_ok,
    output logic [SLOT_W-1:0]     next_slot,
    output logic                  next_ok
);

    logic [LINE_BYTES-1:0] smask [SLOTS];
    logic [SLOTS-1:0]      ne;

    // Per-slot byte masks built from the valid bits and the start offset.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam int LN = (s == LINES) ? 0 : s;
        for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
            logic below;
            assign below = (OFF_W'(b) < offset);
            if (s == 0) begin : g_head
                assign smask[s][b] = valid_all[LN*LINE_BYTES + b] & ~below;
            end else if (s == LINES) begin : g_wrap
                assign smask[s][b] = valid_all[LN*LINE_BYTES + b] & below;
            end else begin : g_mid
                assign smask[s][b] = valid_all[LN*LINE_BYTES + b];
            end
        end
        assign ne[s] = |smask[s];
    end

    // Lowest non-empty slot, and lowest non-empty slot above cur.
    always_comb begin
        first_slot = '0;
        first_ok   = 1'b0;
        next_slot  = '0;
        next_ok    = 1'b0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (ne[s]) begin
                first_slot = SLOT_W'(s);
                first_ok   = 1'b1;
                if (s > int'(cur)) begin
                    next_slot = SLOT_W'(s);
                    next_ok   = 1'b1;
                end
            end
        end
    end

    // Mask of the slot currently being programmed.
    always_comb begin
        cur_mask = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (int'(cur) == s) begin
                cur_mask = smask[s];
            end
        end
    end

endmodule

// File: rtl/wc_timer.sv
// Per-page program window counter.
// Assumes: run stays high for the whole flush; the count restarts at every
// window end and whenever run is low.
module wc_timer #(
    parameter int PAGE_CYC = 250000,
    localparam int CNT_W   = (PAGE_CYC > 1) ? $clog2(PAGE_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic first,
    output logic last
);

    logic [CNT_W-1:0] cnt;

    assign first = (cnt == '0);
    assign last  = (cnt == CNT_W'(PAGE_CYC - 1));

    // Window counting: wraps at PAGE_CYC-1, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wcache_flush.sv
// Multi-page write cache: captures the data bytes of one write command,
// then programs the loaded pages one by one after Stop.
// Assumes: command inputs are single-cycle pulses from the bus slave;
// priority while loading is abort, then stop, then cmd_start, then byte_stb.
module wcache_flush #(
    parameter int ADDR_W     = 13,
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_CYC   = 250000
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cmd_start,
    input  logic [ADDR_W-1:0]                      start_addr,
    input  logic                                   byte_stb,
    input  logic [DATA_W-1:0]                      byte_data,
    input  logic                                   stop,
    input  logic                                   abort,
    output logic                                   busy,
    output logic                                   pg_we,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   pg_page,
    output logic [LINE_BYTES*DATA_W-1:0]           pg_data,
    output logic [LINE_BYTES-1:0]                  pg_mask
);
    import wcache_pkg::*;

    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int LINE_W  = $clog2(LINES);
    localparam int SLOTS_B = LINES * LINE_BYTES;
    localparam int PTR_W   = $clog2(SLOTS_B);
    localparam int PAGE_W  = ADDR_W - OFF_W;
    localparam int SLOTS   = LINES + 1;
    localparam int SLOT_W  = $clog2(SLOTS);

    wc_state_e          state;
    logic [PAGE_W-1:0]  base_pg;
    logic [OFF_W-1:0]   off;
    logic [PTR_W-1:0]   ptr;
    logic [SLOT_W-1:0]  slot;

    logic               clr, wr_en;
    logic [LINE_W-1:0]  rd_line;
    logic [SLOTS_B-1:0] valid_all;
    logic [SLOT_W-1:0]  first_slot, next_slot;
    logic               first_ok, next_ok;
    logic               tm_first, tm_last;
    logic               do_stop, do_abort, do_start, do_byte;

    // Accepted command events in the current state.
    always_comb begin
        do_abort = (state == ST_LOAD) && abort;
        do_stop  = (state == ST_LOAD) && !abort && stop;
        do_start = cmd_start &&
                   ((state == ST_IDLE) || ((state == ST_LOAD) && !abort && !stop));
        do_byte  = (state == ST_LOAD) && byte_stb && !abort && !stop && !cmd_start;
        clr      = do_start || do_abort;
        wr_en    = do_byte;
    end

    // Main controller: command capture, pointer advance, page sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            base_pg <= '0;
            off     <= '0;
            ptr     <= '0;
            slot    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (do_start) begin
                        base_pg <= start_addr[ADDR_W-1:OFF_W];
                        off     <= start_addr[OFF_W-1:0];
                        ptr     <= PTR_W'(start_addr[OFF_W-1:0]);
                        state   <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (do_abort) begin
                        state <= ST_IDLE;
                    end else if (do_stop) begin
                        slot  <= first_slot;
                        state <= first_ok ? ST_PROG : ST_IDLE;
                    end else if (do_start) begin
                        base_pg <= start_addr[ADDR_W-1:OFF_W];
                        off     <= start_addr[OFF_W-1:0];
                        ptr     <= PTR_W'(start_addr[OFF_W-1:0]);
                    end else if (do_byte) begin
                        ptr <= ptr + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (tm_last) begin
                        if (next_ok) begin
                            slot <= next_slot;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Slot to cache line: the wrapped-head slot reads line 0.
    assign rd_line = (slot == SLOT_W'(LINES)) ? '0 : slot[LINE_W-1:0];

    wc_store #(
        .LINES      (LINES),
        .LINE_BYTES (LINE_BYTES),
        .DATA_W     (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wr_en     (wr_en),
        .wr_ptr    (ptr),
        .wr_data   (byte_data),
        .rd_line   (rd_line),
        .rd_data   (pg_data),
        .valid_all (valid_all)
    );

    wc_slots #(
        .LINES      (LINES),
        .LINE_BYTES (LINE_BYTES)
    ) u_slots (
        .valid_all  (valid_all),
        .offset     (off),
        .cur        (slot),
        .cur_mask   (pg_mask),
        .first_slot (first_slot),
        .first_ok   (first_ok),
        .next_slot  (next_slot),
        .next_ok    (next_ok)
    );

    wc_timer #(
        .PAGE_CYC (PAGE_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_PROG),
        .first (tm_first),
        .last  (tm_last)
    );

    // Page program bus outputs.
    assign busy    = (state == ST_PROG);
    assign pg_we   = busy && tm_first;
    assign pg_page = base_pg + PAGE_W'(slot);

endmodule

// File: rtl/wc_checker.sv
// Protocol checker for the write cache, bound to every wcache_flush.
// Keeps its own window counter and checks the program strobes against it.
module wc_checker #(
    parameter int PAGE_CYC   = 250000,
    parameter int LINE_BYTES = 8,
    localparam int CNT_W     = (PAGE_CYC > 1) ? $clog2(PAGE_CYC) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  stop,
    input logic                  busy,
    input logic                  pg_we,
    input logic [LINE_BYTES-1:0] pg_mask
);

    logic [CNT_W-1:0] win;

    // Independent count of cycles within the current page window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            win <= '0;
        end else if (win == CNT_W'(PAGE_CYC - 1)) begin
            win <= '0;
        end else begin
            win <= win + 1'b1;
        end
    end

    assert_we_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pg_we |-> busy);

    assert_mask_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pg_we |-> (pg_mask != '0));

    assert_busy_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop));

    assert_we_cadence_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pg_we == (win == '0)));

    assert_end_on_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(win) == CNT_W'(PAGE_CYC - 1)));

endmodule

bind wcache_flush wc_checker #(
    .PAGE_CYC   (PAGE_CYC),
    .LINE_BYTES (LINE_BYTES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stop    (stop),
    .busy    (busy),
    .pg_we   (pg_we),
    .pg_mask (pg_mask)
);

// File: tb/sim_wcache_flush.sv
// Sweep bench for the write cache with a byte-level model of the array.
module sim_wcache_flush;
    localparam int ADDR_W = 13;
    localparam int PC     = 3;
    localparam int NPAGES = 1 << (ADDR_W - 3);
    localparam int NBYTES = 1 << ADDR_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [12:0] start_addr = '0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop = 1'b0;
    logic        abort = 1'b0;
    logic        busy, pg_we;
    logic [9:0]  pg_page;
    logic [63:0] pg_data;
    logic [7:0]  pg_mask;

    int errs = 0;
    int checks = 0;
    int we_cnt = 0;
    int busy_cnt = 0;
    int cyc = 0;
    logic [7:0] mem_dut [NBYTES];
    logic [7:0] mem_exp [NBYTES];

    always #4 clk = ~clk;

    wcache_flush #(.ADDR_W(ADDR_W), .LINES(8), .LINE_BYTES(8), .DATA_W(8), .PAGE_CYC(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .stop(stop), .abort(abort),
        .busy(busy), .pg_we(pg_we), .pg_page(pg_page), .pg_data(pg_data), .pg_mask(pg_mask)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // Array model driven by the program bus, plus strobe and busy counters.
    always @(negedge clk) begin
        cyc++;
        if (pg_we) begin
            we_cnt++;
            for (int b = 0; b < 8; b++) begin
                if (pg_mask[b]) mem_dut[{pg_page, 3'(b)}] = pg_data[b*8 +: 8];
            end
        end
        if (busy) busy_cnt++;
        if (cyc > 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < NBYTES; i++) begin
            if (mem_dut[i] !== mem_exp[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) chk(1'b1, req, "array", 0, 0);
        else chk(1'b0, req, $sformatf("array mismatches=%0d at addr %0d", bad, first),
                 int'(mem_dut[first]), int'(mem_exp[first]));
    endtask

    function automatic logic [7:0] dval(int seed, int i);
        return 8'((seed * 31 + i * 13 + (i >> 6) * 101) & 255);
    endfunction

    // One write command; pre_n bytes go to pre_a before a restart (R12),
    // noise drives ignored inputs during busy (R9).
    task automatic run_write(input int a, input int n, input int seed, input string req,
                             input int pre_n, input int pre_a, input bit noise);
        logic [7:0] cb [64];
        bit ld [64];
        bit pt [9];
        int off = a % 8;
        int np = 0;
        for (int p = 0; p < 64; p++) ld[p] = 0;
        for (int s = 0; s < 9; s++) pt[s] = 0;
        for (int i = 0; i < n; i++) begin
            cb[(off + i) % 64] = dval(seed, i);
            ld[(off + i) % 64] = 1;
        end
        for (int p = 0; p < 64; p++) begin
            if (ld[p]) begin
                int ln = p / 8;
                int b = p % 8;
                int s = (ln == 0 && b < off) ? 8 : ln;
                int pg = ((a / 8) + s) % NPAGES;
                mem_exp[pg * 8 + b] = cb[p];
                pt[s] = 1;
            end
        end
        for (int s = 0; s < 9; s++) np += pt[s];
        we_cnt = 0;
        busy_cnt = 0;
        if (pre_n > 0) begin
            cmd_start = 1; start_addr = 13'(pre_a);
            @(negedge clk); cmd_start = 0;
            for (int i = 0; i < pre_n; i++) begin
                byte_stb = 1; byte_data = 8'(i + 77);
                @(negedge clk);
            end
            byte_stb = 0;
        end
        cmd_start = 1; start_addr = 13'(a);
        @(negedge clk); cmd_start = 0;
        for (int i = 0; i < n; i++) begin
            byte_stb = 1; byte_data = dval(seed, i);
            @(negedge clk);
        end
        byte_stb = 0;
        chk(we_cnt == 0 && busy_cnt == 0, "R7", "strobes before stop", we_cnt, 0);
        stop = 1;
        @(negedge clk);
        stop = 0;
        while (busy) begin
            if (noise) begin
                cmd_start = 1; start_addr = 13'(a + 24);
                byte_stb = 1; byte_data = 8'hA5;
                stop = (cyc % 3 == 0); abort = (cyc % 5 == 0);
            end
            @(negedge clk);
        end
        cmd_start = 0; byte_stb = 0; stop = 0; abort = 0;
        repeat (3) @(negedge clk);
        chk(we_cnt == np, "R8", "page strobes", we_cnt, np);
        chk(busy_cnt == np * PC, "R8", "busy cycles", busy_cnt, np * PC);
        chk_mem(req);
    endtask

    initial begin
        int lens [12] = '{1, 3, 8, 9, 15, 57, 63, 64, 65, 71, 128, 130};
        for (int i = 0; i < NBYTES; i++) begin
            mem_dut[i] = 8'((i * 7 + 3) & 255);
            mem_exp[i] = 8'((i * 7 + 3) & 255);
        end
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && pg_we == 1'b0 && we_cnt == 0, "R1", "idle after reset", we_cnt, 0);

        // Sweep offsets against lengths; tag depends on which behaviour dominates.
        for (int o = 0; o < 8; o++) begin
            for (int k = 0; k < 12; k++) begin
                int n = lens[k];
                int a = (((o * 97 + k * 131 + 5) % NPAGES) * 8) + o;
                string req;
                if (n > 64) req = "R4";
                else if (o != 0 && o + n > 64) req = "R5";
                else if (o + n <= 8) req = "R6";
                else if (n < 9) req = "R2";
                else req = "R3";
                run_write(a, n, o * 12 + k, req, 0, 0, 1'b0);
            end
        end

        // R3: flush past the top page of the array wraps to page 0.
        run_write((NPAGES - 1) * 8 + 2, 40, 201, "R3", 0, 0, 1'b0);
        // R3: crossing a 4K-bit block boundary (page 63 -> 64).
        run_write(63 * 8 + 5, 20, 202, "R3", 0, 0, 1'b0);

        // R9: inputs driven during busy must be ignored.
        run_write(300 * 8 + 1, 64, 203, "R9", 0, 0, 1'b1);
        chk(busy == 1'b0 && we_cnt == 9, "R9", "no flush from ignored inputs", we_cnt, 9);

        // R12: restart while loading discards the first bytes.
        run_write(700 * 8 + 4, 10, 204, "R12", 6, 100 * 8, 1'b0);

        // R10: abort discards the cache.
        we_cnt = 0; busy_cnt = 0;
        cmd_start = 1; start_addr = 13'(420 * 8);
        @(negedge clk); cmd_start = 0;
        for (int i = 0; i < 10; i++) begin
            byte_stb = 1; byte_data = 8'(i);
            @(negedge clk);
        end
        byte_stb = 0; abort = 1;
        @(negedge clk); abort = 0;
        stop = 1;
        @(negedge clk); stop = 0;
        repeat (6) @(negedge clk);
        chk(we_cnt == 0 && busy_cnt == 0, "R10", "abort programs nothing", we_cnt, 0);
        chk_mem("R10");

        // R11: Stop right after start with no bytes.
        cmd_start = 1; start_addr = 13'(50 * 8 + 3);
        @(negedge clk); cmd_start = 0; stop = 1;
        @(negedge clk); stop = 0;
        repeat (6) @(negedge clk);
        chk(we_cnt == 0 && busy_cnt == 0, "R11", "empty stop", busy_cnt, 0);

        finish_run();
    end

endmodule